// File: doc/BRIEF.md
# Asynchronous Character Receiver

This block takes one serial line that rests at logic 1 and turns each character on it into a parallel byte. A character opens with a falling edge into a low start bit. The receiver detects that edge and arms a bit timer. It confirms the start bit half a bit period later, and then takes one sample per bit period at each bit's centre. From these samples it collects the data bits, an optional parity bit and one or two stop bits. The timer restarts on every start edge, so a small rate mismatch between sender and receiver never builds up past the end of one character.

The bit period, the character length, the parity mode and the number of stop bits are run-time inputs. The receiver captures them at the moment it accepts a start edge, and they stay fixed for the rest of that character. Each finished character appears on the data output with a valid pulse one clock long. Two flags come with it, one for a parity mismatch and one for a stop position that read low. All three outputs hold their values until the next character completes.

Top module: `async_char_rx`

## Requirements
- R1: While reset is high and on the first cycle after it, out_valid, out_data, out_parity_err and out_frame_err are all 0.
- R2: A falling edge on the idle-high line starts a character. The start bit is checked half a bit period (cfg_period clocks per bit) after the edge, and every later bit is sampled one full period after the one before, so a character sent at the nominal rate is received without error.
- R3: Data bits arrive least significant bit first. cfg_len codes 0, 1, 2 and 3 select 5, 6, 7 and 8 bits. The result sits in the low bits of out_data, and every bit above the character length reads 0.
- R4: A cfg_parity value of 1 selects even parity and 2 selects odd parity. In both modes one parity bit follows the data, and out_parity_err is set when the count of ones over the data and parity bits does not match the mode. Values 0 and 3 mean no parity bit, and out_parity_err stays 0.
- R5: cfg_two_stop set to 1 selects two stop bits and 0 selects one. out_frame_err is set when any stop position samples 0.
- R6: If the line reads 1 at the start-bit midpoint, the event is dropped and no character is produced.
- R7: out_valid is high for exactly one cycle per received character, and it is never high on two cycles in a row.
- R8: Each start edge re-aligns the sampling. Characters sent back to back with no idle gap, at a bit rate that is 1/32 away from nominal in either direction, are all received correctly.
- R9: Configuration changes made after a start edge has been accepted do not affect that character.
- R10: If the line stays low after a framing error, no further character starts until the line has gone high and then fallen again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial input, idles high |
| cfg_period | input | CNT_W | Clocks per bit period (at least 4) |
| cfg_len | input | 2 | Character length code (5 + code data bits) |
| cfg_parity | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| out_data | output | 8 | Received character, right-aligned |
| out_valid | output | 1 | One-cycle strobe for a new character |
| out_parity_err | output | 1 | Parity mismatch for the last character |
| out_frame_err | output | 1 | A stop position read 0 for the last character |

## Verification
The checker assumes that cfg_period is at least 4, so the half-period load is never zero. It also assumes the timer reload never lands on the cycle in which the engine drops back to idle. The bench uses a period of 32 and only ever changes configuration inputs between characters, or mid-character when the test is about capture. Line transitions are driven on the falling clock edge, and each bit lasts a whole number of clocks. The mismatched-rate runs stay within 1/32 of a bit per bit, so the accumulated offset over a character with one stop bit stays well inside half a period.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

    localparam int DATA_MAX = 8;
    localparam int LEN_MIN  = 5;

    typedef enum logic [1:0] {
        PAR_NONE = 2'd0,
        PAR_EVEN = 2'd1,
        PAR_ODD  = 2'd2,
        PAR_RSVD = 2'd3
    } parity_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } rx_state_e;

    typedef struct packed {
        logic [1:0]   len_code;
        parity_mode_e parity;
        logic         two_stop;
    } frame_cfg_t;

    typedef struct packed {
        logic [DATA_MAX-1:0] data;
        logic                parity_err;
        logic                frame_err;
    } rx_char_t;

    function automatic logic uses_parity(input parity_mode_e m);
        return (m == PAR_EVEN) || (m == PAR_ODD);
    endfunction

    function automatic logic [2:0] last_bit_index(input logic [1:0] len_code);
        return 3'(LEN_MIN - 1) + {1'b0, len_code};
    endfunction

    function automatic logic [DATA_MAX-1:0] right_align(input logic [DATA_MAX-1:0] sh,
                                                         input logic [1:0] len_code);
        logic [1:0] amount;
        amount = 2'd3 - len_code;
        return sh >> amount;
    endfunction

    function automatic logic parity_bad(input logic [DATA_MAX-1:0] d,
                                        input logic pbit,
                                        input parity_mode_e m);
        logic ones_odd;
        ones_odd = (^d) ^ pbit;
        case (m)
            PAR_EVEN: return ones_odd;
            PAR_ODD:  return ~ones_odd;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b1;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             halt,
    input  logic [CNT_W-1:0] first_cnt,
    input  logic [CNT_W-1:0] period,
    output logic             tick
);
    logic [CNT_W-1:0] cnt;
    logic             run;
    logic [CNT_W-1:0] reload;

    assign reload = period - CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (arm) begin
            run <= 1'b1;
            cnt <= first_cnt;
        end else if (halt) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (run) begin
            if (cnt == '0) cnt <= reload;
            else           cnt <= cnt - CNT_W'(1);
        end
    end

    assign tick = run && (cnt == '0) && !arm;
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
    import async_rx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line,
    input  logic             tick,
    input  frame_cfg_t       cfg_in,
    input  logic [CNT_W-1:0] period_in,
    output logic             arm,
    output logic             halt,
    output logic [CNT_W-1:0] first_cnt,
    output logic [CNT_W-1:0] period_q,
    output frame_cfg_t       cfg_q,
    output rx_state_e        state,
    output rx_char_t         result,
    output logic             valid
);
    logic                line_prev;
    logic [DATA_MAX-1:0] shreg;
    logic [2:0]          bit_idx;
    logic                pbit;
    logic                ferr;
    logic                stop_idx;
    logic                ferr_now;
    logic                start_edge;

    assign start_edge = (state == ST_IDLE) && line_prev && !line;
    assign arm        = start_edge;
    assign halt       = (state == ST_IDLE);
    assign first_cnt  = (period_in >> 1) - CNT_W'(1);
    assign ferr_now   = ferr | ~line;

    always_ff @(posedge clk) begin
        if (rst) begin
            line_prev <= 1'b1;
            state     <= ST_IDLE;
            cfg_q     <= '0;
            period_q  <= '0;
            shreg     <= '0;
            bit_idx   <= '0;
            pbit      <= 1'b0;
            ferr      <= 1'b0;
            stop_idx  <= 1'b0;
            result    <= '0;
            valid     <= 1'b0;
        end else begin
            line_prev <= line;
            valid     <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start_edge) begin
                        state    <= ST_START;
                        cfg_q    <= cfg_in;
                        period_q <= period_in;
                        shreg    <= '0;
                        bit_idx  <= '0;
                        pbit     <= 1'b0;
                        ferr     <= 1'b0;
                        stop_idx <= 1'b0;
                    end
                end
                ST_START: begin
                    if (tick) begin
                        if (line) state <= ST_IDLE;
                        else      state <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (tick) begin
                        shreg <= {line, shreg[DATA_MAX-1:1]};
                        if (bit_idx == last_bit_index(cfg_q.len_code)) begin
                            state <= uses_parity(cfg_q.parity) ? ST_PARITY : ST_STOP;
                        end else begin
                            bit_idx <= bit_idx + 3'd1;
                        end
                    end
                end
                ST_PARITY: begin
                    if (tick) begin
                        pbit  <= line;
                        state <= ST_STOP;
                    end
                end
                ST_STOP: begin
                    if (tick) begin
                        if (cfg_q.two_stop && !stop_idx) begin
                            stop_idx <= 1'b1;
                            ferr     <= ferr_now;
                        end else begin
                            valid             <= 1'b1;
                            result.data       <= right_align(shreg, cfg_q.len_code);
                            result.parity_err <= parity_bad(right_align(shreg, cfg_q.len_code),
                                                            pbit, cfg_q.parity);
                            result.frame_err  <= ferr_now;
                            state             <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/async_char_rx.sv
module async_char_rx
    import async_rx_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_line,
    input  logic [CNT_W-1:0] cfg_period,
    input  logic [1:0]       cfg_len,
    input  logic [1:0]       cfg_parity,
    input  logic             cfg_two_stop,
    output logic [7:0]       out_data,
    output logic             out_valid,
    output logic             out_parity_err,
    output logic             out_frame_err
);
    logic             line_s;
    logic             bit_tick;
    logic             tmr_arm;
    logic             tmr_halt;
    logic [CNT_W-1:0] tmr_first;
    logic [CNT_W-1:0] eng_period;
    frame_cfg_t       cfg_now;
    frame_cfg_t       eng_cfg;
    rx_state_e        eng_state;
    rx_char_t         eng_result;
    logic             eng_valid;

    assign cfg_now.len_code = cfg_len;
    assign cfg_now.parity   = parity_mode_e'(cfg_parity);
    assign cfg_now.two_stop = cfg_two_stop;

    rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rx_line),
        .dout (line_s)
    );

    rx_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .arm       (tmr_arm),
        .halt      (tmr_halt),
        .first_cnt (tmr_first),
        .period    (eng_period),
        .tick      (bit_tick)
    );

    rx_frame_engine #(.CNT_W(CNT_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .line      (line_s),
        .tick      (bit_tick),
        .cfg_in    (cfg_now),
        .period_in (cfg_period),
        .arm       (tmr_arm),
        .halt      (tmr_halt),
        .first_cnt (tmr_first),
        .period_q  (eng_period),
        .cfg_q     (eng_cfg),
        .state     (eng_state),
        .result    (eng_result),
        .valid     (eng_valid)
    );

    assign out_data       = eng_result.data;
    assign out_parity_err = eng_result.parity_err;
    assign out_frame_err  = eng_result.frame_err;
    assign out_valid      = eng_valid;
endmodule

// File: rtl/async_char_rx_checker.sv
module async_char_rx_checker
    import async_rx_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       out_parity_err,
    input logic       bit_tick,
    input rx_state_e  state,
    input frame_cfg_t cfg_q
);
    // R7: strobe never lasts two cycles
    assert_valid_single_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R3: bits above the captured length are zero
    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((out_data >> (4'd5 + {2'b00, cfg_q.len_code})) == 8'd0));

    // R4: without a parity bit no parity error can be reported
    assert_no_parity_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !uses_parity(cfg_q.parity)) |-> !out_parity_err);

    // R2: sample ticks only occur while a character is in progress
    assert_tick_busy_R2: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> (state != ST_IDLE));

    // R6: a character is only delivered after a stop-bit sample
    assert_valid_after_stop_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($past(state) == ST_STOP));
endmodule

bind async_char_rx async_char_rx_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .out_valid      (out_valid),
    .out_data       (out_data),
    .out_parity_err (out_parity_err),
    .bit_tick       (bit_tick),
    .state          (eng_state),
    .cfg_q          (eng_cfg)
);

// File: tb/tb_async_char_rx.sv
module tb_async_char_rx;
    localparam int P = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_line = 1'b1;
    logic [15:0] cfg_period = 16'(P);
    logic [1:0]  cfg_len = 2'd3;
    logic [1:0]  cfg_parity = 2'd0;
    logic        cfg_two_stop = 1'b0;
    logic [7:0]  out_data;
    logic        out_valid;
    logic        out_parity_err;
    logic        out_frame_err;

    async_char_rx dut (
        .clk(clk), .rst(rst), .rx_line(rx_line), .cfg_period(cfg_period),
        .cfg_len(cfg_len), .cfg_parity(cfg_parity), .cfg_two_stop(cfg_two_stop),
        .out_data(out_data), .out_valid(out_valid),
        .out_parity_err(out_parity_err), .out_frame_err(out_frame_err)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct packed {
        logic [7:0] d;
        logic       pe;
        logic       fe;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    task automatic bit_time(input logic v, input int n);
        rx_line = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] data, input logic [1:0] len,
                             input logic [1:0] par, input logic two,
                             input logic par_flip, input logic [1:0] stop_bad,
                             input int bitclk, input int idle,
                             input logic cfg_swap, input string tag);
        logic [7:0] mask;
        logic       pbit;
        exp_t       e;
        mask = 8'((9'd1 << (5 + len)) - 9'd1);
        pbit = (^(data & mask)) ^ (par == 2'd2) ^ par_flip;
        cfg_len = len;
        cfg_parity = par;
        cfg_two_stop = two;
        e.d  = data & mask;
        e.pe = ((par == 2'd1) || (par == 2'd2)) && par_flip;
        e.fe = two ? |stop_bad : stop_bad[0];
        exp_q.push_back(e);
        tag_q.push_back(tag);
        rx_line = 1'b0;
        if (cfg_swap) begin
            repeat (8) @(negedge clk);
            cfg_len = ~len;
            cfg_parity = (par == 2'd0) ? 2'd1 : 2'd0;
            cfg_two_stop = ~two;
            repeat (bitclk - 8) @(negedge clk);
        end else begin
            repeat (bitclk) @(negedge clk);
        end
        for (int i = 0; i < 5 + int'(len); i++) bit_time(data[i], bitclk);
        if (par == 2'd1 || par == 2'd2) bit_time(pbit, bitclk);
        bit_time(~stop_bad[0], bitclk);
        if (two) bit_time(~stop_bad[1], bitclk);
        if (idle > 0) bit_time(1'b1, idle);
    endtask

    // monitor / scoreboard
    logic prev_v = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                chk(!prev_v, "R7", "valid longer than one cycle", 1, 0);
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 R10", "unexpected character", int'(out_data), 0);
                end else begin
                    exp_t  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk({out_data, out_parity_err, out_frame_err} == {e.d, e.pe, e.fe},
                        t, "data/perr/ferr",
                        int'({out_data, out_parity_err, out_frame_err}),
                        int'({e.d, e.pe, e.fe}));
                end
            end
            prev_v = out_valid;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "valid in reset", int'(out_valid), 0);
        chk(out_data == 8'd0, "R1", "data in reset", int'(out_data), 0);
        chk({out_parity_err, out_frame_err} == 2'b00, "R1", "flags in reset",
            int'({out_parity_err, out_frame_err}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk({out_valid, out_data, out_parity_err, out_frame_err} == 11'd0, "R1",
            "outputs after reset", int'({out_valid, out_data}), 0);
        repeat (P) @(negedge clk);

        // R2 nominal 8N1
        send_char(8'hA5, 2'd3, 2'd0, 1'b0, 1'b0, 2'b00, P, P, 1'b0, "R2");
        send_char(8'h3C, 2'd3, 2'd0, 1'b0, 1'b0, 2'b00, P, P, 1'b0, "R2");
        // R3 lengths
        send_char(8'hFF, 2'd0, 2'd0, 1'b0, 1'b0, 2'b00, P, P, 1'b0, "R3");
        send_char(8'hEC, 2'd1, 2'd0, 1'b0, 1'b0, 2'b00, P, P, 1'b0, "R3");
        send_char(8'hD5, 2'd2, 2'd0, 1'b0, 1'b0, 2'b00, P, P, 1'b0, "R3");
        // R4 parity
        send_char(8'h71, 2'd3, 2'd1, 1'b0, 1'b0, 2'b00, P, P, 1'b0, "R4");
        send_char(8'h71, 2'd3, 2'd1, 1'b0, 1'b1, 2'b00, P, P, 1'b0, "R4");
        send_char(8'h16, 2'd2, 2'd2, 1'b0, 1'b0, 2'b00, P, P, 1'b0, "R4");
        send_char(8'h16, 2'd0, 2'd2, 1'b0, 1'b1, 2'b00, P, P, 1'b0, "R4");
        send_char(8'h9E, 2'd3, 2'd3, 1'b0, 1'b0, 2'b00, P, P, 1'b0, "R4");
        // R5 stop bits
        send_char(8'h42, 2'd3, 2'd0, 1'b0, 1'b0, 2'b01, P, P, 1'b0, "R5");
        send_char(8'h43, 2'd3, 2'd1, 1'b1, 1'b0, 2'b00, P, P, 1'b0, "R5");
        send_char(8'h44, 2'd3, 2'd0, 1'b1, 1'b0, 2'b01, P, P, 1'b0, "R5");
        send_char(8'h45, 2'd3, 2'd2, 1'b1, 1'b0, 2'b10, P, P, 1'b0, "R5");

        // R6 glitch, then a clean character
        bit_time(1'b0, 6);
        bit_time(1'b1, 3 * P);
        chk(exp_q.size() == 0, "R6", "pending after glitch", exp_q.size(), 0);
        send_char(8'h5A, 2'd3, 2'd0, 1'b0, 1'b0, 2'b00, P, P, 1'b0, "R6");

        // R8 rate mismatch, back to back
        for (int k = 0; k < 3; k++)
            send_char(8'(8'h81 + k), 2'd3, 2'd0, 1'b0, 1'b0, 2'b00, P - 1, 0, 1'b0, "R8");
        bit_time(1'b1, P);
        for (int k = 0; k < 3; k++)
            send_char(8'(8'hC3 - k), 2'd3, 2'd0, 1'b0, 1'b0, 2'b00, P + 1, 0, 1'b0, "R8");
        bit_time(1'b1, P);

        // R9 configuration swapped mid-character
        send_char(8'h6B, 2'd3, 2'd0, 1'b0, 1'b0, 2'b00, P, P, 1'b1, "R9");
        send_char(8'h0D, 2'd1, 2'd2, 1'b1, 1'b0, 2'b00, P, P, 1'b1, "R9");

        // R10 line held low after a framing error
        send_char(8'h27, 2'd3, 2'd0, 1'b0, 1'b0, 2'b01, P, 0, 1'b0, "R10");
        bit_time(1'b0, 4 * P);
        bit_time(1'b1, 2 * P);
        chk(exp_q.size() == 0, "R10", "pending after break", exp_q.size(), 0);
        send_char(8'hB4, 2'd3, 2'd1, 1'b0, 1'b0, 2'b00, P, P, 1'b0, "R10");

        repeat (3 * P) @(negedge clk);
        chk(exp_q.size() == 0, "R2", "characters never delivered", exp_q.size(), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule